// File: doc/BRIEF.md
# Message-to-Frame Assembler

This block gathers complete 128-bit messages, each made of sixteen 8-bit symbols, into a large frame store held in registers. An upstream packing stage presents a finished message with a single-cycle valid. The block first registers the message. On the next edge it offers that message to every slot of the frame in parallel. A one-hot strobe ring enables the write into exactly one slot.

The ring moves one position for each accepted message, so the slots fill in the same fixed order every time. No address counter, decoder or magnitude comparator is involved. Outside the storage, the logic is a capture register, the ring and a done flag. The only part that grows with the number of slots is the ring, which adds one flop per slot, and one enable gate per slot.

When the last slot is written, a one-cycle done pulse is raised and the ring returns to the first slot. A synchronous clear restarts the fill order without erasing stored data. The whole frame is available as one flat vector.

Top module: `msg_frame_assembler`

## Requirements
- R1: After reset, `slot_onehot` equals 1 (bit 0 set, meaning slot 0 is next), `frame_done` is 0 and every bit of `frame_data` is 0.
- R2: A message presented with `msg_valid` high at a rising edge is stored in the next slot at the following rising edge. Slot k occupies `frame_data[k*128 +: 128]`.
- R3: `slot_onehot` always has exactly one bit set, and bit k marks the slot that the next message will fill. Each stored message moves the set bit from k to k+1, so slots fill in ascending order.
- R4: Storing a message changes only the selected slot. All other slots keep their contents.
- R5: The store into the last slot (index SLOTS-1) makes `frame_done` high for exactly one cycle, the cycle in which that data is visible. In the same cycle, `slot_onehot` returns to 1.
- R6: A high `clr` at a rising edge returns `slot_onehot` to 1. It also drops a message that was captured but not yet stored, and it does not change `frame_data`.
- R7: A `msg_valid` that is high at the same rising edge as `clr` is ignored. No slot is ever written with that message.
- R8: Cycles without `msg_valid` leave `frame_data` and `slot_onehot` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| clr | input | 1 | Synchronous restart of the fill order |
| msg_valid | input | 1 | A complete message is present this cycle |
| msg_data | input | SYM_W*SYMS (128) | Message, symbol 0 in bits 7:0 |
| slot_onehot | output | SLOTS (100) | Strobe ring, bit k set means slot k is next |
| frame_done | output | 1 | One-cycle pulse when the last slot is filled |
| frame_data | output | SLOTS*SYM_W*SYMS (12800) | Frame store, slot 0 in the low 128 bits |

## Verification
The embedded assertions check the following on every cycle:
- the ring stays one-hot;
- each store moves the ring by exactly one position;
- a clear returns the ring to slot 0;
- the done pulse coincides with the wrap from the last slot;
- idle or cleared cycles leave the frame data stable.

The directed scenarios are needed to show the rest:
- the content and placement of each slot across a full frame;
- that no neighbouring slot is disturbed;
- that a message colliding with a clear, or caught between capture and store by a clear, never appears anywhere in the frame.

// File: rtl/msg_frame_assembler.sv
module msg_frame_assembler #(
  parameter int SYM_W = 8,
  parameter int SYMS  = 16,
  parameter int SLOTS = 100
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             clr,
  input  logic                             msg_valid,
  input  logic [SYM_W*SYMS-1:0]            msg_data,
  output logic [SLOTS-1:0]                 slot_onehot,
  output logic                             frame_done,
  output logic [SLOTS*SYM_W*SYMS-1:0]      frame_data
);

  localparam int MSG_W = SYM_W * SYMS;
  localparam logic [SLOTS-1:0] RING_START = {{(SLOTS-1){1'b0}}, 1'b1};

  logic [MSG_W-1:0] cap_msg;
  logic             cap_vld;
  logic             wr_en;

  // Stage 1: capture the complete message; a valid coinciding with clear is dropped.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cap_vld <= 1'b0;
      cap_msg <= '0;
    end else begin
      cap_vld <= msg_valid & ~clr;
      if (msg_valid) cap_msg <= msg_data;
    end
  end

  assign wr_en = cap_vld & ~clr;

  // Rotating strobe ring selects the slot; no comparators.
  always_ff @(posedge clk) begin
    if (!rst_n || clr)
      slot_onehot <= RING_START;
    else if (wr_en)
      slot_onehot <= {slot_onehot[SLOTS-2:0], slot_onehot[SLOTS-1]};
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr) frame_done <= 1'b0;
    else               frame_done <= wr_en & slot_onehot[SLOTS-1];
  end

  // Stage 2: broadcast to all slots, strobe gates the write.
  for (genvar k = 0; k < SLOTS; k++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n)
        frame_data[k*MSG_W +: MSG_W] <= '0;
      else if (wr_en && slot_onehot[k])
        frame_data[k*MSG_W +: MSG_W] <= cap_msg;
    end
  end

  assert_ring_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(slot_onehot) == 1);

  assert_ring_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en) |=> (slot_onehot == {$past(slot_onehot[SLOTS-2:0]), $past(slot_onehot[SLOTS-1])}));

  assert_done_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> (slot_onehot[0] && $past(slot_onehot[SLOTS-1])));

  assert_clear_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (slot_onehot == RING_START && !frame_done && $stable(frame_data)));

  assert_idle_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!cap_vld && !clr) |=> ($stable(frame_data) && $stable(slot_onehot)));

  assert_collide_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && clr) |=> !cap_vld);

endmodule

// File: tb/msg_frame_assembler_tb_top.sv
module msg_frame_assembler_tb_top;
  localparam int SLOTS = 100;
  localparam int MW = 128;

  logic clk = 0;
  logic rst_n = 0;
  logic clr = 0;
  logic msg_valid = 0;
  logic [MW-1:0] msg_data = '0;
  logic [SLOTS-1:0] slot_onehot;
  logic frame_done;
  logic [SLOTS*MW-1:0] frame_data;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [MW-1:0] exp_slot [SLOTS];
  int ptr = 0;

  always #10 clk = ~clk;

  msg_frame_assembler dut_i (
    .clk(clk), .rst_n(rst_n), .clr(clr), .msg_valid(msg_valid),
    .msg_data(msg_data), .slot_onehot(slot_onehot),
    .frame_done(frame_done), .frame_data(frame_data));

  function automatic logic [MW-1:0] pat(int k, int seed);
    logic [31:0] a, b;
    a = 32'(seed) * 32'h9E37 + 32'(k);
    b = 32'(k) * 32'h0101_0101 ^ 32'(seed);
    return {a, b, ~a, ~b ^ 32'hC3C3_5A5A};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [MW-1:0] act, input logic [MW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic compare_all(input string tag);
    logic [SLOTS-1:0] ring_exp;
    ring_exp = '0;
    ring_exp[ptr] = 1'b1;
    for (int k = 0; k < SLOTS; k++)
      chk(frame_data[k*MW +: MW] === exp_slot[k], tag, frame_data[k*MW +: MW], exp_slot[k]);
    chk(slot_onehot === ring_exp, tag, MW'(slot_onehot), MW'(ring_exp));
  endtask

  task automatic send(input logic [MW-1:0] d);
    @(negedge clk); msg_valid = 1; msg_data = d;
    @(negedge clk); msg_valid = 0;
    @(negedge clk);
    exp_slot[ptr] = d;
    ptr = (ptr + 1) % SLOTS;
  endtask

  task automatic t_reset;
    for (int k = 0; k < SLOTS; k++) exp_slot[k] = '0;
    ptr = 0;
    @(negedge clk);
    chk(frame_done === 1'b0, "R1 done after reset", MW'(frame_done), 0);
    compare_all("R1 reset state");
  endtask

  task automatic t_full_frame;
    for (int i = 0; i < 102; i++) begin
      @(negedge clk);
      chk(frame_done === (i == 101), "R5 done pulse timing", MW'(frame_done), MW'(i == 101));
      if (i == 101) chk(slot_onehot[0] === 1'b1, "R5 ring wraps with done", MW'(slot_onehot), 1);
      msg_valid = (i < 100);
      msg_data  = pat(i, 7);
    end
    msg_valid = 0;
    @(negedge clk);
    chk(frame_done === 1'b0, "R5 done lasts one cycle", MW'(frame_done), 0);
    for (int k = 0; k < SLOTS; k++) exp_slot[k] = pat(k, 7);
    ptr = 0;
    compare_all("R2 R3 full frame order");
  endtask

  task automatic t_gapped;
    for (int j = 0; j < 4; j++) begin
      send(pat(j, 99));
      compare_all("R4 single slot written");
      repeat (3) @(negedge clk);
      compare_all("R8 idle cycles no change");
    end
  endtask

  task automatic t_clear_mid;
    @(negedge clk); clr = 1;
    @(negedge clk); clr = 0;
    ptr = 0;
    compare_all("R6 clear keeps data and restarts ring");
    send(pat(0, 55));
    compare_all("R6 after clear writes slot 0");
  endtask

  task automatic t_valid_with_clear;
    send(pat(1, 55));
    @(negedge clk); msg_valid = 1; clr = 1; msg_data = pat(0, 1234);
    @(negedge clk); msg_valid = 0; clr = 0;
    @(negedge clk);
    ptr = 0;
    compare_all("R7 valid with clear ignored");
    @(negedge clk);
    compare_all("R7 no late write");
  endtask

  task automatic t_pending_drop;
    send(pat(2, 55));
    @(negedge clk); msg_valid = 1; msg_data = pat(0, 4321);
    @(negedge clk); msg_valid = 0; clr = 1;
    @(negedge clk); clr = 0;
    ptr = 0;
    compare_all("R6 pending message dropped");
    @(negedge clk);
    compare_all("R6 no late write after drop");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_full_frame();
    t_gapped();
    t_clear_mid();
    t_valid_with_clear();
    t_pending_drop();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule